// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits between a command decoder and three execution engines (2D, 3D and compute). Each incoming register write carries a method number, a subchannel number and a 32-bit value. The block keeps a small binding table that records, for each subchannel, which engine class the subchannel has been tied to at run time. It then steers every ordinary write to the engine port that the subchannel's class selects.

Method numbers below a reserved limit (0x100) are handled inside the block and never reach an engine. Method 0 writes the binding table. Every other method in that range is dropped and flagged as unimplemented. Writes that cannot be delivered set sticky status bits, and a clear input resets those bits. These cases are a write to an unbound subchannel, an attempt to rebind a bound subchannel, and a write to a subchannel bound to a class with no engine behind it.

A forwarded write appears on its engine port one cycle after acceptance, as a single-cycle valid pulse with the method and value. The input is held off (ready low) while the write at the input would go to an engine whose ready is low. Writes that go to other engines, and writes the block handles itself, are not held off.

Top module: `subch_router`

## Requirements
- R1: After reset every subchannel is unbound, all engine valid outputs are low and `stsFlags` is zero. A reset applied later in operation also erases every binding.
- R2: An accepted write with method 0 on an unbound subchannel stores the low 16 bits of the value as that subchannel's class. No engine port is driven and no status bit is set.
- R3: A method-0 write on a subchannel that is already bound sets `stsFlags[0]` (rebind error) and leaves the existing binding unchanged. Later writes still follow the first class.
- R4: An accepted write with a method from 0x001 to 0x0FF sets `stsFlags[1]` (reserved method) and is not forwarded. This holds whether or not the subchannel is bound.
- R5: An accepted write with method 0x100 or above on an unbound subchannel sets `stsFlags[2]` (unbound error) and is not forwarded.
- R6: An accepted write with method 0x100 or above is forwarded according to the subchannel's class: 0x902D goes to the 2D port, 0xB197 to the 3D port and 0xB1C0 to the compute port. On the cycle after acceptance exactly that port's valid is high, carrying the input method and value. The valid lasts one cycle unless another write follows.
- R7: A write with method 0x100 or above on a subchannel bound to any other class sets `stsFlags[3]` (unsupported class) and is not forwarded. The classes 0xA140 and 0xB0B5 are included here, as is any unknown value.
- R8: `inReady` is low exactly when `inValid` is high and the write would be forwarded to a port whose ready is low. While stalled, nothing is forwarded and no status bit changes. Writes to other ports and internally handled writes are not stalled.
- R9: Status bits are sticky until `statusClr` is high at a clock edge. A bit set in the same cycle as `statusClr` ends up set.
- R10: The 8 subchannels are independent. Binding or using one subchannel does not change the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming write present |
| inReady | output | 1 | Incoming write accepted this cycle when high with inValid |
| inSubch | input | 3 | Subchannel of the write |
| inMethod | input | 12 | Method number of the write |
| inData | input | 32 | Value of the write |
| statusClr | input | 1 | Clears all status bits |
| stsFlags | output | 4 | Sticky status: [0] rebind, [1] reserved method, [2] unbound, [3] unsupported class |
| eng2dValid | output | 1 | Write pulse to 2D engine |
| eng2dMethod | output | 12 | Method to 2D engine |
| eng2dData | output | 32 | Value to 2D engine |
| eng2dReady | input | 1 | 2D engine can take a write |
| eng3dValid | output | 1 | Write pulse to 3D engine |
| eng3dMethod | output | 12 | Method to 3D engine |
| eng3dData | output | 32 | Value to 3D engine |
| eng3dReady | input | 1 | 3D engine can take a write |
| engCmpValid | output | 1 | Write pulse to compute engine |
| engCmpMethod | output | 12 | Method to compute engine |
| engCmpData | output | 32 | Value to compute engine |
| engCmpReady | input | 1 | Compute engine can take a write |

## Verification
The hardest case to reach is a stall that holds back one engine while writes to another engine, or reserved-method writes, must still pass. To reach it, the stimulus first binds subchannels to each class through method-0 writes and then drops a single engine's ready in the middle of a pending write. It checks that `inReady` falls at once, that no status bit moves, and that the write lands only after ready returns. A rebind attempt on a live subchannel followed by an ordinary write shows that the original class still steers the traffic.

// File: rtl/subch_router_pkg.sv
package subch_router_pkg;

  localparam int NUM_ENG = 3;

  typedef enum logic [1:0] {
    ENG_2D   = 2'd0,
    ENG_3D   = 2'd1,
    ENG_CMP  = 2'd2,
    ENG_NONE = 2'd3
  } eng_sel_e;

  localparam logic [15:0] CLS_2D  = 16'h902D;
  localparam logic [15:0] CLS_3D  = 16'hB197;
  localparam logic [15:0] CLS_CMP = 16'hB1C0;

  localparam int STS_REBIND   = 0;
  localparam int STS_RESERVED = 1;
  localparam int STS_UNBOUND  = 2;
  localparam int STS_UNSUP    = 3;
  localparam int STS_W        = 4;

  typedef struct packed {
    logic     bindWr;
    logic     fwdEn;
    eng_sel_e fwdSel;
    logic     setRebind;
    logic     setReserved;
    logic     setUnbound;
    logic     setUnsup;
  } ctrl_strb_t;

endpackage

// File: rtl/subch_ctrl.sv
module subch_ctrl
  import subch_router_pkg::*;
#(
  parameter int METHOD_W      = 12,
  parameter int CLASS_W       = 16,
  parameter int SPECIAL_LIMIT = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [METHOD_W-1:0] inMethod,
  input  logic                lkValid,
  input  logic [CLASS_W-1:0]  lkClass,
  input  logic [NUM_ENG-1:0]  engReady,
  output logic                inReady,
  output ctrl_strb_t          strb
);

  localparam logic [METHOD_W-1:0] LIMIT_M = METHOD_W'(SPECIAL_LIMIT);

  logic     isBind;
  logic     isSpecial;
  eng_sel_e routeSel;
  logic     portRdy;
  logic     needPort;
  logic     accept;

  assign isBind    = (inMethod == '0);
  assign isSpecial = (inMethod < LIMIT_M);

  always_comb begin
    routeSel = ENG_NONE;
    if (lkClass == CLASS_W'(CLS_2D))       routeSel = ENG_2D;
    else if (lkClass == CLASS_W'(CLS_3D))  routeSel = ENG_3D;
    else if (lkClass == CLASS_W'(CLS_CMP)) routeSel = ENG_CMP;
  end

  always_comb begin
    portRdy = 1'b0;
    for (int k = 0; k < NUM_ENG; k++) begin
      if (int'(routeSel) == k) portRdy = engReady[k];
    end
  end

  assign needPort = inValid && !isSpecial && lkValid && (routeSel != ENG_NONE);
  assign inReady  = !needPort || portRdy;
  assign accept   = inValid && inReady;

  always_comb begin
    strb        = '0;
    strb.fwdSel = ENG_NONE;
    if (accept) begin
      if (isBind) begin
        if (lkValid) strb.setRebind = 1'b1;
        else         strb.bindWr    = 1'b1;
      end else if (isSpecial) begin
        strb.setReserved = 1'b1;
      end else if (!lkValid) begin
        strb.setUnbound = 1'b1;
      end else if (routeSel == ENG_NONE) begin
        strb.setUnsup = 1'b1;
      end else begin
        strb.fwdEn  = 1'b1;
        strb.fwdSel = routeSel;
      end
    end
  end

  AST_STALL_ONLY_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |-> (!isSpecial && lkValid)) else $error("stall on non-forward write"); // R8

  AST_SPECIAL_NO_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isSpecial) |-> !strb.fwdEn) else $error("special method forwarded"); // R4

endmodule

// File: rtl/subch_dpath.sv
module subch_dpath
  import subch_router_pkg::*;
#(
  parameter int SUBCH_N  = 8,
  parameter int METHOD_W = 12,
  parameter int DATA_W   = 32,
  parameter int CLASS_W  = 16,
  localparam int SUB_W   = $clog2(SUBCH_N)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [SUB_W-1:0]                  inSubch,
  input  logic [METHOD_W-1:0]               inMethod,
  input  logic [DATA_W-1:0]                 inData,
  input  logic                              statusClr,
  input  ctrl_strb_t                        strb,
  output logic                              lkValid,
  output logic [CLASS_W-1:0]                lkClass,
  output logic [NUM_ENG-1:0]                engValid,
  output logic [NUM_ENG-1:0][METHOD_W-1:0]  engMethod,
  output logic [NUM_ENG-1:0][DATA_W-1:0]    engData,
  output logic [STS_W-1:0]                  stsFlags
);

  logic [SUBCH_N-1:0]              tblValid;
  logic [SUBCH_N-1:0][CLASS_W-1:0] tblClass;
  logic [STS_W-1:0]                stsSet;

  for (genvar i = 0; i < SUBCH_N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblValid[i] <= 1'b0;
        tblClass[i] <= '0;
      end else if (strb.bindWr && (inSubch == SUB_W'(i))) begin
        tblValid[i] <= 1'b1;
        tblClass[i] <= inData[CLASS_W-1:0];
      end
    end

    AST_BIND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      tblValid[i] |=> (tblValid[i] && $stable(tblClass[i]))) else $error("binding changed"); // R3
  end

  assign lkValid = tblValid[inSubch];
  assign lkClass = tblClass[inSubch];

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        engValid[k]  <= 1'b0;
        engMethod[k] <= '0;
        engData[k]   <= '0;
      end else begin
        engValid[k] <= strb.fwdEn && (int'(strb.fwdSel) == k);
        if (strb.fwdEn && (int'(strb.fwdSel) == k)) begin
          engMethod[k] <= inMethod;
          engData[k]   <= inData;
        end
      end
    end
  end

  always_comb begin
    stsSet               = '0;
    stsSet[STS_REBIND]   = strb.setRebind;
    stsSet[STS_RESERVED] = strb.setReserved;
    stsSet[STS_UNBOUND]  = strb.setUnbound;
    stsSet[STS_UNSUP]    = strb.setUnsup;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stsFlags <= '0;
    else       stsFlags <= (stsFlags & {STS_W{!statusClr}}) | stsSet;
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(engValid)) else $error("several ports driven"); // R6

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !statusClr |=> ((stsFlags & $past(stsFlags)) == $past(stsFlags))) else $error("status bit lost"); // R9

endmodule

// File: rtl/subch_router.sv
module subch_router
  import subch_router_pkg::*;
#(
  parameter int SUBCH_N       = 8,
  parameter int METHOD_W      = 12,
  parameter int DATA_W        = 32,
  parameter int CLASS_W       = 16,
  parameter int SPECIAL_LIMIT = 256,
  localparam int SUB_W        = $clog2(SUBCH_N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SUB_W-1:0]    inSubch,
  input  logic [METHOD_W-1:0] inMethod,
  input  logic [DATA_W-1:0]   inData,
  input  logic                statusClr,
  output logic [STS_W-1:0]    stsFlags,
  output logic                eng2dValid,
  output logic [METHOD_W-1:0] eng2dMethod,
  output logic [DATA_W-1:0]   eng2dData,
  input  logic                eng2dReady,
  output logic                eng3dValid,
  output logic [METHOD_W-1:0] eng3dMethod,
  output logic [DATA_W-1:0]   eng3dData,
  input  logic                eng3dReady,
  output logic                engCmpValid,
  output logic [METHOD_W-1:0] engCmpMethod,
  output logic [DATA_W-1:0]   engCmpData,
  input  logic                engCmpReady
);

  ctrl_strb_t                       strb;
  logic                             lkValid;
  logic [CLASS_W-1:0]               lkClass;
  logic [NUM_ENG-1:0]               engReadyVec;
  logic [NUM_ENG-1:0]               engValidVec;
  logic [NUM_ENG-1:0][METHOD_W-1:0] engMethodVec;
  logic [NUM_ENG-1:0][DATA_W-1:0]   engDataVec;

  assign engReadyVec = {engCmpReady, eng3dReady, eng2dReady};

  subch_ctrl #(
    .METHOD_W      (METHOD_W),
    .CLASS_W       (CLASS_W),
    .SPECIAL_LIMIT (SPECIAL_LIMIT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMethod (inMethod),
    .lkValid  (lkValid),
    .lkClass  (lkClass),
    .engReady (engReadyVec),
    .inReady  (inReady),
    .strb     (strb)
  );

  subch_dpath #(
    .SUBCH_N  (SUBCH_N),
    .METHOD_W (METHOD_W),
    .DATA_W   (DATA_W),
    .CLASS_W  (CLASS_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .inSubch   (inSubch),
    .inMethod  (inMethod),
    .inData    (inData),
    .statusClr (statusClr),
    .strb      (strb),
    .lkValid   (lkValid),
    .lkClass   (lkClass),
    .engValid  (engValidVec),
    .engMethod (engMethodVec),
    .engData   (engDataVec),
    .stsFlags  (stsFlags)
  );

  assign eng2dValid   = engValidVec[0];
  assign eng2dMethod  = engMethodVec[0];
  assign eng2dData    = engDataVec[0];
  assign eng3dValid   = engValidVec[1];
  assign eng3dMethod  = engMethodVec[1];
  assign eng3dData    = engDataVec[1];
  assign engCmpValid  = engValidVec[2];
  assign engCmpMethod = engMethodVec[2];
  assign engCmpData   = engDataVec[2];

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_chk
    AST_FWD_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
      engValidVec[k] |-> $past(engReadyVec[k])) else $error("forward without ready"); // R8
  end

  AST_SPECIAL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inMethod < METHOD_W'(SPECIAL_LIMIT))) |=> (engValidVec == '0))
    else $error("special write reached an engine"); // R2

endmodule

// File: tb/subch_router_bench.sv
module subch_router_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;
  localparam int VW = 3 + 12 + 32 + 2 + 4;

  // fields: subch, method, data, expected port (0 none,1 2D,2 3D,3 compute), expected status
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 12'h000, 32'h0000_902D, 2'd0, 4'h0},
    {3'd1, 12'h000, 32'h0000_B197, 2'd0, 4'h0},
    {3'd2, 12'h000, 32'h0000_B1C0, 2'd0, 4'h0},
    {3'd3, 12'h000, 32'h0000_A140, 2'd0, 4'h0},
    {3'd4, 12'h000, 32'h0000_B0B5, 2'd0, 4'h0},
    {3'd5, 12'h000, 32'h5A5A_902D, 2'd0, 4'h0},
    {3'd0, 12'h100, 32'h1111_0001, 2'd1, 4'h0},
    {3'd1, 12'h1A0, 32'h2222_0002, 2'd2, 4'h0},
    {3'd2, 12'hFFF, 32'h3333_0003, 2'd3, 4'h0},
    {3'd3, 12'h200, 32'h0000_0004, 2'd0, 4'h8},
    {3'd4, 12'h100, 32'h0000_0005, 2'd0, 4'h8},
    {3'd5, 12'h100, 32'hCAFE_0006, 2'd1, 4'h0},
    {3'd6, 12'h100, 32'h0000_0007, 2'd0, 4'h4},
    {3'd7, 12'h0FF, 32'h0000_0008, 2'd0, 4'h2},
    {3'd0, 12'h001, 32'h0000_0009, 2'd0, 4'h2},
    {3'd0, 12'h000, 32'h0000_B197, 2'd0, 4'h1},
    {3'd0, 12'h101, 32'h4444_000A, 2'd1, 4'h0},
    {3'd7, 12'h000, 32'h0000_B197, 2'd0, 4'h0},
    {3'd7, 12'h2AB, 32'h5555_000B, 2'd2, 4'h0},
    {3'd6, 12'h0FF, 32'h0000_000C, 2'd0, 4'h2},
    {3'd1, 12'h100, 32'hFFFF_FFFF, 2'd2, 4'h0},
    {3'd6, 12'h000, 32'h0000_1234, 2'd0, 4'h0},
    {3'd6, 12'h100, 32'h0000_000D, 2'd0, 4'h8}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  inSubch = '0;
  logic [11:0] inMethod = '0;
  logic [31:0] inData = '0;
  logic        statusClr = 1'b0;
  logic [3:0]  stsFlags;
  logic        eng2dValid, eng3dValid, engCmpValid;
  logic [11:0] eng2dMethod, eng3dMethod, engCmpMethod;
  logic [31:0] eng2dData, eng3dData, engCmpData;
  logic        eng2dReady = 1'b1, eng3dReady = 1'b1, engCmpReady = 1'b1;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subch_router u_subch_router (
    .clk, .rstN, .inValid, .inReady, .inSubch, .inMethod, .inData, .statusClr, .stsFlags,
    .eng2dValid, .eng2dMethod, .eng2dData, .eng2dReady,
    .eng3dValid, .eng3dMethod, .eng3dData, .eng3dReady,
    .engCmpValid, .engCmpMethod, .engCmpData, .engCmpReady
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one write after a falling edge; returns at the next falling edge
  task automatic send(input logic [2:0] s, input logic [11:0] m, input logic [31:0] d, input logic clr);
    inSubch = s; inMethod = m; inData = d; inValid = 1'b1; statusClr = clr;
    @(negedge clk);
    inValid = 1'b0; statusClr = 1'b0;
  endtask

  task automatic clearSts();
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
  endtask

  function automatic logic [2:0] portVec(input logic [1:0] e);
    return (e == 2'd1) ? 3'b001 : (e == 2'd2) ? 3'b010 : (e == 2'd3) ? 3'b100 : 3'b000;
  endfunction

  initial begin
    logic [2:0]  vs;
    logic [11:0] vm;
    logic [31:0] vd;
    logic [1:0]  ve;
    logic [3:0]  vsts;
    string       req;

    repeat (3) @(negedge clk);
    chk("R1 valids in reset", {61'd0, engCmpValid, eng3dValid, eng2dValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", stsFlags, 4'h0);
    chk("R1 idle ready", inReady, 1'b1);

    for (int i = 0; i < NV; i++) begin
      {vs, vm, vd, ve, vsts} = VEC[i];
      clearSts();
      send(vs, vm, vd, 1'b0);
      if (ve != 0)      req = "R6";
      else if (vsts[0]) req = "R3";
      else if (vsts[1]) req = "R4";
      else if (vsts[2]) req = "R5 R10";
      else if (vsts[3]) req = "R7";
      else              req = "R2";
      chk(req, {61'd0, engCmpValid, eng3dValid, eng2dValid}, {61'd0, portVec(ve)});
      chk(req, stsFlags, vsts);
      if (ve == 2'd1) chk(req, {eng2dMethod, eng2dData}, {vm, vd});
      if (ve == 2'd2) chk(req, {eng3dMethod, eng3dData}, {vm, vd});
      if (ve == 2'd3) chk(req, {engCmpMethod, engCmpData}, {vm, vd});
    end

    // R6 single-cycle pulse
    send(3'd2, 12'h150, 32'hABCD_0150, 1'b0);
    chk("R6 compute pulse", engCmpValid, 1'b1);
    @(negedge clk);
    chk("R6 pulse ends", {61'd0, engCmpValid, eng3dValid, eng2dValid}, 64'd0);

    // R8 stall on 3D port
    clearSts();
    eng3dReady = 1'b0;
    inSubch = 3'd1; inMethod = 12'h100; inData = 32'h0000_0077; inValid = 1'b1;
    #1;
    chk("R8 ready low on busy port", inReady, 1'b0);
    @(negedge clk);
    chk("R8 nothing forwarded while stalled", {61'd0, engCmpValid, eng3dValid, eng2dValid}, 64'd0);
    chk("R8 status unchanged while stalled", stsFlags, 4'h0);
    eng3dReady = 1'b1;
    #1;
    chk("R8 ready returns", inReady, 1'b1);
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 delivered after ready", {eng3dValid, eng3dData}, {1'b1, 32'h0000_0077});

    eng3dReady = 1'b0;
    inSubch = 3'd0; inMethod = 12'h120; inData = 32'h0000_0088; inValid = 1'b1;
    #1;
    chk("R8 other port not stalled", inReady, 1'b1);
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 other port delivers", {eng2dValid, eng2dData}, {1'b1, 32'h0000_0088});
    inSubch = 3'd1; inMethod = 12'h005; inValid = 1'b1;
    #1;
    chk("R8 reserved write not stalled", inReady, 1'b1);
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 R4 reserved flagged", stsFlags, 4'h2);
    eng3dReady = 1'b1;

    // R9 sticky and set-over-clear
    @(negedge clk);
    chk("R9 sticky across idle", stsFlags, 4'h2);
    clearSts();
    chk("R9 clear", stsFlags, 4'h0);
    send(3'd6, 12'h100, 32'h0, 1'b1);
    chk("R9 set wins over clear", stsFlags, 4'h8);

    // R1 reset erases bindings
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 status cleared by reset", stsFlags, 4'h0);
    rstN = 1'b1;
    @(negedge clk);
    send(3'd0, 12'h100, 32'h99, 1'b0);
    chk("R1 binding erased", stsFlags, 4'h4);
    chk("R1 no forward after reset", {61'd0, engCmpValid, eng3dValid, eng2dValid}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule